// File: doc/BRIEF.md
# Radio Frame Interrupt Event Sequencer

This block follows a packet radio frame one octet at a time and raises interrupt events at fixed points of the frame. On the receive side it watches a stream of demodulated octets that carry a valid strobe. A flag marks the start-of-frame delimiter octet, and a frame-filter verdict comes from a neighbouring block. On the transmit side it takes a start strobe with the frame length, then one strobe for each octet that leaves the modulator. It holds the transceiver state and records every event in a status register that clears when it is read. An interrupt line is raised for the events that are enabled.

On air a frame is a four-octet preamble, a one-octet delimiter, a one-octet length header, then the MAC header, the payload and a two-octet checksum. The length header counts the octets from the first MAC header octet through the last checksum octet. The block counts body octets against that value to find the frame end. Demodulation, checksum calculation and address filtering happen elsewhere. This block only sequences events and states.

Top module: `rfevt_seq`

## Requirements
- R1: After reset, `trx_state` is 0 (listening), `irq_stat` is 0 and `irq` is low.
- R2: While listening, the first valid octet after the delimiter octet (`rx_vld` with `rx_sfd` high) is the length header, whose length is in bits [6:0]. If that length is non-zero, the same clock edge sets status bit 0 (frame start) and moves `trx_state` to 1 (busy receiving).
- R3: A length header whose length bits are zero raises no event and leaves the state at 0. The octet that follows is not taken as a length header; the block waits for a new delimiter.
- R4: Status bit 1 (address match) is set when the body octet whose index (counting from 1) equals `mhr_len` is taken, only if `filt_pass` is high in that cycle, `mhr_len` is at least 1 and `mhr_len`+2 does not exceed the frame length. `mhr_len` is sampled together with the length header.
- R5: When the body octet whose index equals the frame length is taken, status bit 2 (frame end) is set and `trx_state` returns to 0 at the same edge.
- R6: In state 2 (PLL ready), `tx_start` with a non-zero `tx_len` moves the state to 3 (busy transmitting). After `tx_len`+6 `tx_octet_done` strobes, status bit 2 is set and the state returns to 2 at the edge of the last strobe.
- R7: `tx_start` is ignored when `tx_len` is zero, and in any state other than 2.
- R8: Outside a frame, `tx_mode` high moves state 0 to state 2 and `tx_mode` low moves state 2 to state 0, one edge later. While the state is 1 or 3 it has no effect.
- R9: A cycle with `stat_rd` high clears every status bit at its edge. An event that occurs in the same cycle is kept set.
- R10: `irq` is high exactly when some status bit is set and its bit in `irq_mask` is 1. A masked event still sets its status bit.
- R11: Received octets and the delimiter flag are ignored in states 2 and 3. A delimiter flag inside a frame body is counted as a body octet and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_mode | input | 1 | Requests PLL-ready (1) or listening (0) when idle |
| rx_vld | input | 1 | A received octet is present this cycle |
| rx_data | input | 8 | Received octet |
| rx_sfd | input | 1 | Marks the current octet as the delimiter |
| filt_pass | input | 1 | Frame-filter verdict, used on the last MAC header octet |
| mhr_len | input | 7 | MAC header length in octets |
| tx_start | input | 1 | Begin transmitting a frame |
| tx_len | input | 7 | Length header value of the frame to send |
| tx_octet_done | input | 1 | One transmitted octet has left |
| irq_mask | input | 3 | Per-event interrupt enable (bit0 start, bit1 match, bit2 end) |
| stat_rd | input | 1 | Status read strobe; clears the status |
| trx_state | output | 2 | 0 listening, 1 busy rx, 2 PLL ready, 3 busy tx |
| irq_stat | output | 3 | Event status (bit0 start, bit1 match, bit2 end) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are the ones where two things land on one edge. One is a status read that coincides with the final body octet, so the clear and the frame-end event meet. The other is a frame whose header does not fit its declared length. The directed tasks build each frame octet by octet on falling edges. This places the read strobe exactly on the last octet, and chooses `mhr_len` against the length header so that the fit rule and the filter verdict are tested separately. Zero-length headers, reserved-bit headers, delimiter flags inside a body and mode changes during busy states are each driven at the point where a faulty sequencer would react.

// File: rtl/rfevt_pkg.sv
// Shared types and event bit positions for the frame event sequencer.
package rfevt_pkg;
    // Transceiver state; the encoding is visible on the trx_state port.
    typedef enum logic [1:0] {
        TRX_RX_ON   = 2'd0,
        TRX_BUSY_RX = 2'd1,
        TRX_PLL_ON  = 2'd2,
        TRX_BUSY_TX = 2'd3
    } trx_state_e;

    // Receive parser phase.
    typedef enum logic [1:0] {
        PH_HUNT = 2'd0,
        PH_LEN  = 2'd1,
        PH_BODY = 2'd2
    } rx_phase_e;

    localparam int EV_START = 0;
    localparam int EV_ADDR  = 1;
    localparam int EV_END   = 2;
    localparam int EV_NUM   = 3;
endpackage

// File: rtl/rfevt_rx_track.sv
// Receive octet tracker: hunts for the delimiter, captures the length
// header, counts body octets and emits start, address-match and end
// events as single-cycle pulses in the cycle the octet is taken.
// Assumes one octet per rx_vld cycle; the parser is held in hunt while en is low.
module rfevt_rx_track
    import rfevt_pkg::*;
#(
    parameter int OCT_W = 8,
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rx_vld,
    input  logic [OCT_W-1:0] rx_data,
    input  logic             rx_sfd,
    input  logic             filt_pass,
    input  logic [LEN_W-1:0] mhr_len,
    output logic             ev_start,
    output logic             ev_addr,
    output logic             ev_end
);
    localparam logic [LEN_W:0] FCS_OCT = (LEN_W+1)'(2);

    rx_phase_e        phase_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] mhr_q;
    logic [LEN_W-1:0] idx_q;
    logic             fits_q;

    logic             take;
    logic [LEN_W-1:0] phr_len;
    logic [LEN_W:0]   idx_nxt;
    logic [LEN_W:0]   hdr_need;
    logic             rx_unused_bits;

    // Decode the length field and the next body index.
    always_comb begin
        take     = en && rx_vld;
        phr_len  = rx_data[LEN_W-1:0];
        idx_nxt  = {1'b0, idx_q} + (LEN_W+1)'(1);
        hdr_need = {1'b0, mhr_len} + FCS_OCT;
    end

    assign rx_unused_bits = ^rx_data[OCT_W-1:LEN_W];

    // Event pulses, valid in the cycle the octet is taken.
    always_comb begin
        ev_start = (phase_q == PH_LEN) && take && (phr_len != '0);
        ev_addr  = (phase_q == PH_BODY) && take && fits_q && filt_pass &&
                   (idx_nxt == {1'b0, mhr_q});
        ev_end   = (phase_q == PH_BODY) && take && (idx_nxt == {1'b0, len_q});
    end

    // Phase, length capture and body counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            phase_q <= PH_HUNT;
            len_q   <= '0;
            mhr_q   <= '0;
            idx_q   <= '0;
            fits_q  <= 1'b0;
        end else if (take) begin
            case (phase_q)
                PH_HUNT: if (rx_sfd) phase_q <= PH_LEN;
                PH_LEN: begin
                    if (phr_len != '0) begin
                        phase_q <= PH_BODY;
                        len_q   <= phr_len;
                        mhr_q   <= mhr_len;
                        idx_q   <= '0;
                        fits_q  <= (mhr_len != '0) && (hdr_need <= {1'b0, phr_len});
                    end else begin
                        phase_q <= PH_HUNT;
                    end
                end
                PH_BODY: begin
                    idx_q <= idx_nxt[LEN_W-1:0];
                    if (idx_nxt == {1'b0, len_q}) phase_q <= PH_HUNT;
                end
                default: phase_q <= PH_HUNT;
            endcase
        end
    end

    // R4: an address match only happens inside a frame body and when the header fits.
    assert_addr_in_body_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_addr |-> (phase_q == PH_BODY) && fits_q);

    // R5: the body index never runs past the captured length.
    assert_idx_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_BODY) |-> (idx_q < len_q));
endmodule

// File: rtl/rfevt_tx_track.sv
// Transmit octet tracker: on an accepted start it loads the total on-air
// octet count (length header value plus preamble, delimiter and header
// octets) and counts done strobes down to the frame end.
// Assumes tx_octet_done pulses once per octet sent; strobes while idle are dropped.
module rfevt_tx_track #(
    parameter int LEN_W   = 7,
    parameter int PRE_OCT = 4,
    parameter int SFD_OCT = 1,
    parameter int PHR_OCT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_ok,
    input  logic             tx_start,
    input  logic [LEN_W-1:0] tx_len,
    input  logic             tx_octet_done,
    output logic             ev_begin,
    output logic             ev_end
);
    localparam int OVH   = PRE_OCT + SFD_OCT + PHR_OCT;
    localparam int TXC_W = $clog2((1 << LEN_W) + OVH);

    logic             busy_q;
    logic [TXC_W-1:0] cnt_q;
    logic [TXC_W-1:0] total_q;
    logic [TXC_W-1:0] cnt_nxt;

    // Start acceptance and end detection.
    always_comb begin
        cnt_nxt  = cnt_q + TXC_W'(1);
        ev_begin = !busy_q && start_ok && tx_start && (tx_len != '0);
        ev_end   = busy_q && tx_octet_done && (cnt_nxt == total_q);
    end

    // Busy flag and sent-octet counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            total_q <= '0;
        end else if (ev_begin) begin
            busy_q  <= 1'b1;
            cnt_q   <= '0;
            total_q <= TXC_W'(tx_len) + TXC_W'(OVH);
        end else if (busy_q && tx_octet_done) begin
            cnt_q <= cnt_nxt;
            if (cnt_nxt == total_q) busy_q <= 1'b0;
        end
    end

    // R6: the count stays below the frame total while transmitting.
    assert_tx_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q < total_q));
endmodule

// File: rtl/rfevt_irq_regs.sv
// Interrupt status and request: each event pulse sets its own sticky bit,
// a read strobe clears all bits in one cycle (a same-cycle event survives),
// and the request line is the OR of the unmasked bits.
module rfevt_irq_regs #(
    parameter int NEV = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] ev,
    input  logic [NEV-1:0] mask,
    input  logic           rd,
    output logic [NEV-1:0] stat,
    output logic           irq
);
    logic [NEV-1:0] stat_q;
    logic [NEV-1:0] pend;

    genvar k;
    generate
        for (k = 0; k < NEV; k++) begin : g_bit
            // Sticky status bit with clear-on-read; a set beats the clear.
            always_ff @(posedge clk) begin
                if (!rst_n)     stat_q[k] <= 1'b0;
                else if (ev[k]) stat_q[k] <= 1'b1;
                else if (rd)    stat_q[k] <= 1'b0;
            end
            assign pend[k] = stat_q[k] & mask[k];
        end
    endgenerate

    assign stat = stat_q;
    assign irq  = |pend;

    // R9: a read with no new events leaves nothing set.
    assert_rd_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (ev == '0)) |=> (stat_q == '0));

    // R9: an event is never lost, even if it meets a read.
    assert_ev_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((stat_q & $past(ev)) == $past(ev)));

    // R10: with nothing recorded the request line is low.
    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q == '0) |-> !irq);
endmodule

// File: rtl/rfevt_seq.sv
// Frame event sequencer top: owns the transceiver state, routes octet
// streams to the receive and transmit trackers and gathers their events
// into the interrupt status block.
// Assumes rx and tx octet streams are already aligned to clk.
module rfevt_seq
    import rfevt_pkg::*;
#(
    parameter int OCT_W   = 8,
    parameter int LEN_W   = 7,
    parameter int PRE_OCT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_mode,
    input  logic              rx_vld,
    input  logic [OCT_W-1:0]  rx_data,
    input  logic              rx_sfd,
    input  logic              filt_pass,
    input  logic [LEN_W-1:0]  mhr_len,
    input  logic              tx_start,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic              tx_octet_done,
    input  logic [EV_NUM-1:0] irq_mask,
    input  logic              stat_rd,
    output logic [1:0]        trx_state,
    output logic [EV_NUM-1:0] irq_stat,
    output logic              irq
);
    trx_state_e        state_q;
    trx_state_e        state_d;
    logic              rx_en;
    logic              tx_ok;
    logic              rx_start_ev;
    logic              rx_addr_ev;
    logic              rx_end_ev;
    logic              tx_begin_ev;
    logic              tx_end_ev;
    logic [EV_NUM-1:0] ev_vec;

    // Enables for the two trackers follow the transceiver state.
    always_comb begin
        rx_en = (state_q == TRX_RX_ON) || (state_q == TRX_BUSY_RX);
        tx_ok = (state_q == TRX_PLL_ON);
    end

    rfevt_rx_track #(.OCT_W(OCT_W), .LEN_W(LEN_W)) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rx_en),
        .rx_vld    (rx_vld),
        .rx_data   (rx_data),
        .rx_sfd    (rx_sfd),
        .filt_pass (filt_pass),
        .mhr_len   (mhr_len),
        .ev_start  (rx_start_ev),
        .ev_addr   (rx_addr_ev),
        .ev_end    (rx_end_ev)
    );

    rfevt_tx_track #(.LEN_W(LEN_W), .PRE_OCT(PRE_OCT)) tx_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_ok      (tx_ok),
        .tx_start      (tx_start),
        .tx_len        (tx_len),
        .tx_octet_done (tx_octet_done),
        .ev_begin      (tx_begin_ev),
        .ev_end        (tx_end_ev)
    );

    // Event vector in status bit order.
    always_comb begin
        ev_vec           = '0;
        ev_vec[EV_START] = rx_start_ev;
        ev_vec[EV_ADDR]  = rx_addr_ev;
        ev_vec[EV_END]   = rx_end_ev | tx_end_ev;
    end

    rfevt_irq_regs #(.NEV(EV_NUM)) irq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev_vec),
        .mask  (irq_mask),
        .rd    (stat_rd),
        .stat  (irq_stat),
        .irq   (irq)
    );

    // Next transceiver state; frame starts take priority over mode changes.
    always_comb begin
        state_d = state_q;
        case (state_q)
            TRX_RX_ON:   if (rx_start_ev) state_d = TRX_BUSY_RX;
                         else if (tx_mode) state_d = TRX_PLL_ON;
            TRX_BUSY_RX: if (rx_end_ev)   state_d = TRX_RX_ON;
            TRX_PLL_ON:  if (tx_begin_ev) state_d = TRX_BUSY_TX;
                         else if (!tx_mode) state_d = TRX_RX_ON;
            TRX_BUSY_TX: if (tx_end_ev)   state_d = TRX_PLL_ON;
            default:     state_d = TRX_RX_ON;
        endcase
    end

    // Transceiver state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRX_RX_ON;
        else        state_q <= state_d;
    end

    assign trx_state = state_q;

    // R2: an accepted length header enters busy-receive with the start bit set.
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRX_RX_ON && rx_start_ev) |=>
            (state_q == TRX_BUSY_RX) && irq_stat[EV_START]);

    // R5: the last body octet returns to listening with the end bit set.
    assert_end_listen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRX_BUSY_RX && rx_end_ev) |=>
            (state_q == TRX_RX_ON) && irq_stat[EV_END]);

    // R8: busy-receive is held until the frame ends, whatever tx_mode does.
    assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRX_BUSY_RX && !rx_end_ev) |=> (state_q == TRX_BUSY_RX));

    // R8: busy-transmit is held until the last octet is sent.
    assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRX_BUSY_TX && !tx_end_ev) |=> (state_q == TRX_BUSY_TX));
endmodule

// File: tb/rfevt_seq_tb_top.sv
// Directed bench for the frame event sequencer: one task per scenario.
module rfevt_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_mode = 1'b0;
    logic       rx_vld = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_sfd = 1'b0;
    logic       filt_pass = 1'b0;
    logic [6:0] mhr_len = '0;
    logic       tx_start = 1'b0;
    logic [6:0] tx_len = '0;
    logic       tx_octet_done = 1'b0;
    logic [2:0] irq_mask = '0;
    logic       stat_rd = 1'b0;
    logic [1:0] trx_state;
    logic [2:0] irq_stat;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rfevt_seq dut_i (
        .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .rx_vld(rx_vld),
        .rx_data(rx_data), .rx_sfd(rx_sfd), .filt_pass(filt_pass),
        .mhr_len(mhr_len), .tx_start(tx_start), .tx_len(tx_len),
        .tx_octet_done(tx_octet_done), .irq_mask(irq_mask), .stat_rd(stat_rd),
        .trx_state(trx_state), .irq_stat(irq_stat), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One received octet; returns at the next falling edge.
    task automatic rx_oct(input logic [7:0] d, input logic sfd, input logic pass, input logic rd);
        rx_vld = 1'b1; rx_data = d; rx_sfd = sfd; filt_pass = pass; stat_rd = rd;
        @(negedge clk);
        rx_vld = 1'b0; rx_sfd = 1'b0; filt_pass = 1'b0; stat_rd = 1'b0;
    endtask

    task automatic shr();
        for (int i = 0; i < 4; i++) rx_oct(8'h00, 1'b0, 1'b0, 1'b0);
        rx_oct(8'hA7, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic rd_stat();
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 state", trx_state, 0);
        chk("R1 stat", irq_stat, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_rx_main();
        irq_mask = 3'b111; mhr_len = 7'd3;
        shr();
        chk("R2 no event before header", irq_stat, 0);
        rx_oct(8'd8, 1'b0, 1'b0, 1'b0);
        chk("R2 start bit", irq_stat, 1);
        chk("R2 busy rx", trx_state, 1);
        chk("R10 irq on start", irq, 1);
        rd_stat();
        chk("R9 cleared", irq_stat, 0);
        chk("R10 irq low after clear", irq, 0);
        rx_oct(8'h11, 1'b0, 1'b1, 1'b0);
        rx_oct(8'h22, 1'b0, 1'b1, 1'b0);
        chk("R4 no match early", irq_stat, 0);
        rx_oct(8'h33, 1'b0, 1'b1, 1'b0);
        chk("R4 match on last header octet", irq_stat, 2);
        rx_oct(8'h44, 1'b0, 1'b0, 1'b0);
        rx_oct(8'h55, 1'b1, 1'b0, 1'b0);
        rx_oct(8'h66, 1'b0, 1'b0, 1'b0);
        rx_oct(8'h77, 1'b0, 1'b0, 1'b0);
        chk("R11 sfd inside body counted", trx_state, 1);
        chk("R11 no extra events", irq_stat, 2);
        rx_oct(8'h88, 1'b0, 1'b0, 1'b0);
        chk("R5 end bit", irq_stat, 6);
        chk("R5 back to listening", trx_state, 0);
        rd_stat();
    endtask

    task automatic t_rx_nopass();
        irq_mask = 3'b111; mhr_len = 7'd2;
        shr();
        rx_oct(8'd5, 1'b0, 1'b0, 1'b0);
        tx_mode = 1'b1;
        rx_oct(8'h01, 1'b0, 1'b0, 1'b0);
        rx_oct(8'h02, 1'b0, 1'b0, 1'b0);
        chk("R8 tx_mode ignored in busy rx", trx_state, 1);
        rx_oct(8'h03, 1'b0, 1'b0, 1'b0);
        rx_oct(8'h04, 1'b0, 1'b0, 1'b0);
        rx_oct(8'h05, 1'b0, 1'b0, 1'b0);
        chk("R4 filter fail no match", irq_stat, 5);
        chk("R5 listening at end", trx_state, 0);
        @(negedge clk);
        chk("R8 mode to pll ready", trx_state, 2);
        tx_mode = 1'b0;
        @(negedge clk);
        chk("R8 mode back to listening", trx_state, 0);
        rd_stat();
    endtask

    task automatic t_rx_nofit();
        mhr_len = 7'd3;
        shr();
        rx_oct(8'd4, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) rx_oct(8'h10, 1'b0, 1'b1, 1'b0);
        chk("R4 header too long no match", irq_stat, 5);
        rd_stat();
    endtask

    task automatic t_zero_len();
        shr();
        rx_oct(8'h00, 1'b0, 1'b0, 1'b0);
        chk("R3 zero header no event", irq_stat, 0);
        chk("R3 zero header stays listening", trx_state, 0);
        rx_oct(8'h05, 1'b0, 1'b0, 1'b0);
        chk("R3 next octet not a header", trx_state, 0);
        chk("R3 next octet no event", irq_stat, 0);
        shr();
        rx_oct(8'h80, 1'b0, 1'b0, 1'b0);
        chk("R3 reserved bit only is zero length", trx_state, 0);
        chk("R3 reserved bit only no event", irq_stat, 0);
    endtask

    task automatic t_mask();
        irq_mask = 3'b100; mhr_len = 7'd1;
        shr();
        rx_oct(8'd3, 1'b0, 1'b0, 1'b0);
        chk("R10 masked start no irq", irq, 0);
        chk("R10 masked start bit set", irq_stat, 1);
        rx_oct(8'h01, 1'b0, 1'b1, 1'b0);
        chk("R10 masked match bit set", irq_stat, 3);
        chk("R10 masked match no irq", irq, 0);
        rx_oct(8'h02, 1'b0, 1'b0, 1'b0);
        rx_oct(8'h03, 1'b0, 1'b0, 1'b0);
        chk("R10 unmasked end irq", irq, 1);
        chk("R10 all bits", irq_stat, 7);
        rd_stat();
        irq_mask = 3'b111;
    endtask

    task automatic t_read_collide();
        mhr_len = 7'd0;
        shr();
        rx_oct(8'd2, 1'b0, 1'b1, 1'b0);
        rx_oct(8'h01, 1'b0, 1'b1, 1'b0);
        chk("R4 zero header length no match", irq_stat, 1);
        rx_oct(8'h02, 1'b0, 1'b0, 1'b1);
        chk("R9 end kept over read", irq_stat, 4);
        chk("R5 listening after collide", trx_state, 0);
        rd_stat();
    endtask

    task automatic t_tx();
        tx_start = 1'b1; tx_len = 7'd3;
        @(negedge clk);
        tx_start = 1'b0;
        chk("R7 start ignored while listening", trx_state, 0);
        tx_mode = 1'b1;
        @(negedge clk);
        chk("R8 pll ready", trx_state, 2);
        shr();
        rx_oct(8'd5, 1'b0, 1'b0, 1'b0);
        chk("R11 rx ignored in pll ready", irq_stat, 0);
        chk("R11 state kept", trx_state, 2);
        tx_start = 1'b1; tx_len = 7'd0;
        @(negedge clk);
        tx_start = 1'b0;
        chk("R7 zero length start ignored", trx_state, 2);
        tx_start = 1'b1; tx_len = 7'd3;
        @(negedge clk);
        tx_start = 1'b0;
        chk("R6 busy tx", trx_state, 3);
        tx_mode = 1'b0;
        for (int i = 0; i < 8; i++) begin
            tx_octet_done = 1'b1; @(negedge clk);
            tx_octet_done = 1'b0; @(negedge clk);
        end
        chk("R8 held in busy tx", trx_state, 3);
        chk("R6 no end before last octet", irq_stat, 0);
        tx_octet_done = 1'b1; @(negedge clk); tx_octet_done = 1'b0;
        chk("R6 end bit", irq_stat, 4);
        chk("R6 back to pll ready", trx_state, 2);
        @(negedge clk);
        chk("R8 listening after tx", trx_state, 0);
        rd_stat();
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_main();
        t_rx_nopass();
        t_rx_nofit();
        t_zero_len();
        t_mask();
        t_read_collide();
        t_tx();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule